// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table held in memory. A walk begins when `start` is pulsed; the block then takes a table base and a virtual address. It reads the first-level descriptor through a single-word memory read port. From that descriptor it either ends the walk, with a section mapping or a fault, or reads one second-level descriptor from a coarse or fine table and maps a large, small or tiny page.

A walk ends with a one-cycle `done` pulse. The physical address, the two cacheable/bufferable attribute bits and a fault flag are registered in the same cycle and held until the next walk ends. A build parameter controls tiny-page support. When it is off, a first-level descriptor that points at a fine table counts as a fault. Access permissions, domains, caching of translations and the memory itself belong to other blocks.

Top module: `tablewalk_unit`

## Requirements
- R1: The first read of a walk goes to the word address formed from table base bits 31:14 in bits 31:14, virtual address bits 31:20 in bits 13:2, and zero in bits 1:0.
- R2: A first-level descriptor whose bits 1:0 are 00 ends the walk with `fault`=1, `pa`=0, `cb`=0, and exactly one read is issued.
- R3: A first-level descriptor with bits 1:0 = 10 is a section: `pa` = descriptor bits 31:20 joined with virtual address bits 19:0, `cb` = descriptor bits 3:2, `fault`=0, one read only.
- R4: A first-level descriptor with bits 1:0 = 01 selects a coarse table: the second read address is descriptor bits 31:10 in bits 31:10 with virtual address bits 19:12 in bits 9:2.
- R5: A first-level descriptor with bits 1:0 = 11 (tiny support on) selects a fine table: the second read address is descriptor bits 31:12 in bits 31:12 with virtual address bits 19:10 in bits 11:2.
- R6: Second-level bits 1:0 choose the page: 01 large (descriptor 31:16 with VA 15:0), 10 small (descriptor 31:12 with VA 11:0), 11 tiny (descriptor 31:10 with VA 9:0); `cb` = second-level bits 3:2, `fault`=0.
- R7: A second-level descriptor whose bits 1:0 are 00 ends the walk with `fault`=1, `pa`=0, `cb`=0 after exactly two reads.
- R8: With tiny support off, a first-level descriptor with bits 1:0 = 11 ends the walk with `fault`=1 and no second read.
- R9: At most one read is outstanding: `mem_req` stays high with `mem_addr` unchanged until `mem_rvalid`, and every read address has bits 1:0 = 00.
- R10: `done` is high for exactly one cycle per walk, it comes only in the cycle after a response is accepted, and `pa`, `cb` and `fault` are valid while it is high.
- R11: A `start` pulse that arrives while a walk is in progress is ignored, and the running walk's reads and result are unaffected.
- R12: While `rst` is high and after it falls, the walker is idle with `done`, `fault` and `mem_req` low.
- R13: A `start` in the cycle where `done` is high is accepted, and the new walk runs without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk when idle |
| ttb | input | 32 | Translation table base, sampled with start |
| va | input | 32 | Virtual address, sampled with start |
| mem_req | output | 1 | Read request, held until the response |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read response valid; accepted in that cycle |
| mem_rdata | input | 32 | Read response data |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk ended on a fault descriptor |
| pa | output | 32 | Physical address (zero on fault) |
| cb | output | 2 | Cacheable/bufferable bits of the mapping |

## Verification
The completion pulse of one walk and the acceptance of the next `start` can fall in the same cycle. The bench provokes this by driving `start` with a new table base and address in the very cycle it observes `done` high. It then judges the first walk's held result in that cycle. It also judges the second walk's read addresses, its read count and its translated result, all against precomputed values. A related collision occurs when `start` arrives while a read is still pending. This case is judged by checking that the running walk's reads and result match the vector of the original request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned TTB_LSB   = 14;  // first-level table alignment
  localparam int unsigned SECT_LSB  = 20;  // section size / first-level index
  localparam int unsigned CRS_LSB   = 10;  // coarse table alignment
  localparam int unsigned FINE_LSB  = 12;  // fine table alignment
  localparam int unsigned LARGE_LSB = 16;
  localparam int unsigned SMALL_LSB = 12;
  localparam int unsigned TINY_LSB  = 10;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00,
    L2_LARGE = 2'b01,
    L2_SMALL = 2'b10,
    L2_TINY  = 2'b11
  } l2_kind_e;

  typedef enum logic [1:0] {
    WS_IDLE   = 2'b00,
    WS_FIRST  = 2'b01,
    WS_SECOND = 2'b10
  } walk_state_e;

endpackage

// File: rtl/ptw_l1_addr.sv
module ptw_l1_addr
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:TTB_LSB]  ttb_hi,
  input  logic [WORD_W-1:SECT_LSB] va_hi,
  output logic [WORD_W-1:0]        l1_addr
);

  always_comb begin
    l1_addr = {ttb_hi, va_hi, 2'b00};
  end

endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
#(
  parameter bit TINY_EN = 1'b1
) (
  input  logic [WORD_W-1:0]   desc,
  input  logic [SECT_LSB-1:0] va_lo,
  output logic                is_fault,
  output logic                is_section,
  output logic [WORD_W-1:0]   next_addr,
  output logic [WORD_W-1:0]   sect_pa,
  output logic [1:0]          sect_cb
);

  l1_kind_e kind;
  logic     fine_allowed;
  logic     unused_desc_mid;

  generate
    if (TINY_EN) begin : g_fine_on
      assign fine_allowed = 1'b1;
    end else begin : g_fine_off
      assign fine_allowed = 1'b0;
    end
  endgenerate

  assign unused_desc_mid = ^desc[CRS_LSB-1:4];

  always_comb begin
    kind       = l1_kind_e'(desc[1:0]);
    is_fault   = (kind == L1_FAULT) || ((kind == L1_FINE) && !fine_allowed);
    is_section = (kind == L1_SECTION);
    sect_pa    = {desc[WORD_W-1:SECT_LSB], va_lo};
    sect_cb    = desc[3:2];
    if (kind == L1_FINE) begin
      next_addr = {desc[WORD_W-1:FINE_LSB], va_lo[SECT_LSB-1:TINY_LSB], 2'b00};
    end else begin
      next_addr = {desc[WORD_W-1:CRS_LSB], va_lo[SECT_LSB-1:SMALL_LSB], 2'b00};
    end
  end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0]   desc,
  input  logic [SECT_LSB-1:0] va_lo,
  output logic                is_fault,
  output logic [WORD_W-1:0]   page_pa,
  output logic [1:0]          page_cb
);

  l2_kind_e kind;
  logic     unused_desc_mid;

  assign unused_desc_mid = ^desc[TINY_LSB-1:4];

  always_comb begin
    kind     = l2_kind_e'(desc[1:0]);
    is_fault = (kind == L2_FAULT);
    page_cb  = desc[3:2];
    unique case (kind)
      L2_LARGE: page_pa = {desc[WORD_W-1:LARGE_LSB], va_lo[LARGE_LSB-1:0]};
      L2_SMALL: page_pa = {desc[WORD_W-1:SMALL_LSB], va_lo[SMALL_LSB-1:0]};
      L2_TINY:  page_pa = {desc[WORD_W-1:TINY_LSB],  va_lo[TINY_LSB-1:0]};
      default:  page_pa = '0;
    endcase
  end

endmodule

// File: rtl/tablewalk_unit.sv
module tablewalk_unit
  import ptw_pkg::*;
#(
  parameter bit TINY_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ttb,
  input  logic [WORD_W-1:0] va,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [WORD_W-1:0] pa,
  output logic [1:0]        cb
);

  walk_state_e         state;
  logic [SECT_LSB-1:0] va_lo_q;
  logic [WORD_W-1:0]   first_addr;
  logic                l1_fault, l1_section;
  logic [WORD_W-1:0]   l1_next, l1_pa;
  logic [1:0]          l1_cb;
  logic                l2_fault;
  logic [WORD_W-1:0]   l2_pa;
  logic [1:0]          l2_cb;
  logic                unused_ttb_lo;

  assign unused_ttb_lo = ^ttb[TTB_LSB-1:0];

  ptw_l1_addr u_l1_addr (
    .ttb_hi  (ttb[WORD_W-1:TTB_LSB]),
    .va_hi   (va[WORD_W-1:SECT_LSB]),
    .l1_addr (first_addr)
  );

  ptw_l1_decode #(.TINY_EN(TINY_EN)) u_l1_dec (
    .desc       (mem_rdata),
    .va_lo      (va_lo_q),
    .is_fault   (l1_fault),
    .is_section (l1_section),
    .next_addr  (l1_next),
    .sect_pa    (l1_pa),
    .sect_cb    (l1_cb)
  );

  ptw_l2_decode u_l2_dec (
    .desc     (mem_rdata),
    .va_lo    (va_lo_q),
    .is_fault (l2_fault),
    .page_pa  (l2_pa),
    .page_cb  (l2_cb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WS_IDLE;
      va_lo_q  <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
      pa       <= '0;
      cb       <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (start) begin
            va_lo_q  <= va[SECT_LSB-1:0];
            mem_addr <= first_addr;
            mem_req  <= 1'b1;
            state    <= WS_FIRST;
          end
        end
        WS_FIRST: begin
          if (mem_rvalid) begin
            if (l1_fault || l1_section) begin
              mem_req <= 1'b0;
              done    <= 1'b1;
              fault   <= l1_fault;
              pa      <= l1_fault ? '0 : l1_pa;
              cb      <= l1_fault ? 2'b00 : l1_cb;
              state   <= WS_IDLE;
            end else begin
              mem_addr <= l1_next;
              state    <= WS_SECOND;
            end
          end
        end
        WS_SECOND: begin
          if (mem_rvalid) begin
            mem_req <= 1'b0;
            done    <= 1'b1;
            fault   <= l2_fault;
            pa      <= l2_fault ? '0 : l2_pa;
            cb      <= l2_fault ? 2'b00 : l2_cb;
            state   <= WS_IDLE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_walk_checker.sv
module ptw_walk_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        done,
  input logic        fault,
  input logic [31:0] pa,
  input logic [1:0]  cb
);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_word_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_req_drop_on_resp_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_req) && !$past(rst)) |-> $past(mem_rvalid));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_resp_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_rvalid) && !mem_req));

  assert_fault_zero_result_R10: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (pa == 32'h0 && cb == 2'b00));

endmodule

bind tablewalk_unit ptw_walk_checker u_walk_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .fault      (fault),
  .pa         (pa),
  .cb         (cb)
);

// File: tb/tablewalk_unit_test.sv
`timescale 1ns/1ps
module tablewalk_unit_test;

  typedef struct packed {
    logic [31:0] ttb;
    logic [31:0] va;
    logic [31:0] d1;
    logic [31:0] d2;
    logic [31:0] l1a;
    logic [31:0] l2a;
    logic [31:0] pa;
    logic [1:0]  cb;
    logic        flt;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h12345678, 32'hABC12345, 32'h8760000E, 32'h00000000, 32'h12346AF0, 32'h00000000, 32'h87612345, 2'd3, 1'b0, 2'd1},
    '{32'h00008000, 32'h00305ABC, 32'h40000401, 32'h9999A006, 32'h0000800C, 32'h40000414, 32'h9999AABC, 2'd1, 1'b0, 2'd2},
    '{32'h00004000, 32'h00FF1234, 32'h20000C01, 32'h55550009, 32'h0000403C, 32'h20000FC4, 32'h55551234, 2'd2, 1'b0, 2'd2},
    '{32'h00010000, 32'hFFF789AB, 32'h30001003, 32'h77777C07, 32'h00013FFC, 32'h30001788, 32'h77777DAB, 2'd1, 1'b0, 2'd2},
    '{32'h00020000, 32'h00100C00, 32'h0ABCD003, 32'h11112002, 32'h00020004, 32'h0ABCD00C, 32'h11112C00, 2'd0, 1'b0, 2'd2},
    '{32'h00000000, 32'h00500000, 32'hFFFFFFFC, 32'h00000000, 32'h00000014, 32'h00000000, 32'h00000000, 2'd0, 1'b1, 2'd1},
    '{32'h00000000, 32'h00601000, 32'h00001001, 32'hFFFFFFF0, 32'h00000018, 32'h00001004, 32'h00000000, 2'd0, 1'b1, 2'd2},
    '{32'h00000000, 32'h00700123, 32'h00002001, 32'hABCDEC0F, 32'h0000001C, 32'h00002000, 32'hABCDED23, 2'd3, 1'b0, 2'd2},
    '{32'hFFFFFFFF, 32'h00000000, 32'hFFF00002, 32'h00000000, 32'hFFFFC000, 32'h00000000, 32'hFFF00000, 2'd0, 1'b0, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ttb = '0, va = '0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        done, fault;
  logic [31:0] pa;
  logic [1:0]  cb;

  logic        start_nt = 1'b0;
  logic [31:0] ttb_nt = '0, va_nt = '0;
  logic        req_nt, rvalid_nt = 1'b0;
  logic [31:0] addr_nt, rdata_nt = '0;
  logic        done_nt, fault_nt;
  logic [31:0] pa_nt;
  logic [1:0]  cb_nt;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int cnt      = 0;
  int rd_n     = 0;
  logic [31:0] rd_addr [4];
  int rd_n_nt  = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  tablewalk_unit uut (
    .clk(clk), .rst(rst), .start(start), .ttb(ttb), .va(va),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .pa(pa), .cb(cb)
  );

  tablewalk_unit #(.TINY_EN(1'b0)) uut_nt (
    .clk(clk), .rst(rst), .start(start_nt), .ttb(ttb_nt), .va(va_nt),
    .mem_req(req_nt), .mem_addr(addr_nt), .mem_rvalid(rvalid_nt), .mem_rdata(rdata_nt),
    .done(done_nt), .fault(fault_nt), .pa(pa_nt), .cb(cb_nt)
  );

  function automatic logic [31:0] mem_lookup(input logic [31:0] a);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].l1a == a) return VEC[i].d1;
      if (VEC[i].nrd == 2'd2 && VEC[i].l2a == a) return VEC[i].d2;
    end
    return 32'h0;
  endfunction

  // memory model for the main instance, latency set by lat
  always @(negedge clk) begin
    if (rst || mem_rvalid) begin
      mem_rvalid <= 1'b0;
      cnt <= 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_lookup(mem_addr);
        if (rd_n < 4) rd_addr[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  // memory model for the instance without tiny support, zero latency
  always @(negedge clk) begin
    if (rst || rvalid_nt) begin
      rvalid_nt <= 1'b0;
    end else if (req_nt) begin
      rvalid_nt <= 1'b1;
      rdata_nt  <= mem_lookup(addr_nt);
      rd_n_nt   <= rd_n_nt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] t, input logic [31:0] v);
    @(negedge clk);
    rd_n  = 0;
    ttb   = t;
    va    = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R10", "done seen", {31'b0, done}, 32'd1);
  endtask

  task automatic check_result(input int i);
    string rt;
    rt = VEC[i].flt ? ((VEC[i].nrd == 2'd1) ? "R2" : "R7")
                    : ((VEC[i].nrd == 2'd1) ? "R3" : "R6");
    chk(fault == VEC[i].flt, rt, "fault", {31'b0, fault}, {31'b0, VEC[i].flt});
    chk(pa == VEC[i].pa, rt, "pa", pa, VEC[i].pa);
    chk(cb == VEC[i].cb, rt, "cb", {30'b0, cb}, {30'b0, VEC[i].cb});
    chk(rd_n == int'(VEC[i].nrd), "R9", "read count", rd_n, {30'b0, VEC[i].nrd});
    chk(rd_addr[0] == VEC[i].l1a, "R1", "first read addr", rd_addr[0], VEC[i].l1a);
    if (VEC[i].nrd == 2'd2)
      chk(rd_addr[1] == VEC[i].l2a, (VEC[i].d1[1:0] == 2'b01) ? "R4" : "R5",
          "second read addr", rd_addr[1], VEC[i].l2a);
  endtask

  initial begin
    // reset state, R12
    repeat (3) @(negedge clk);
    chk(!done && !fault && !mem_req, "R12", "idle in reset",
        {29'b0, done, fault, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fault && !mem_req, "R12", "idle after reset",
        {29'b0, done, fault, mem_req}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      lat = i % 4;
      launch(VEC[i].ttb, VEC[i].va);
      wait_done();
      check_result(i);
      @(negedge clk);
      chk(!done, "R10", "done single cycle", {31'b0, done}, 32'd0);
    end

    // R11: start while a walk is pending is ignored
    lat = 3;
    launch(VEC[1].ttb, VEC[1].va);
    ttb = VEC[0].ttb;
    va  = VEC[0].va;
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_result(1);
    chk(pa == VEC[1].pa, "R11", "busy start ignored", pa, VEC[1].pa);

    // R13: new start in the done cycle
    lat = 1;
    launch(VEC[2].ttb, VEC[2].va);
    wait_done();
    check_result(2);
    rd_n  = 0;
    ttb   = VEC[4].ttb;
    va    = VEC[4].va;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_req && mem_addr == VEC[4].l1a, "R13", "back-to-back request",
        mem_addr, VEC[4].l1a);
    wait_done();
    check_result(4);
    chk(pa == VEC[4].pa, "R13", "back-to-back result", pa, VEC[4].pa);

    // R12: reset in the middle of a walk
    lat = 3;
    launch(VEC[3].ttb, VEC[3].va);
    rst = 1'b1;
    @(negedge clk);
    chk(!mem_req && !done && !fault, "R12", "mid-walk reset idle",
        {29'b0, done, fault, mem_req}, 32'd0);
    rst = 1'b0;
    lat = 0;
    launch(VEC[8].ttb, VEC[8].va);
    wait_done();
    check_result(8);

    // R8: tiny support off
    @(negedge clk);
    rd_n_nt  = 0;
    ttb_nt   = VEC[3].ttb;
    va_nt    = VEC[3].va;
    start_nt = 1'b1;
    @(negedge clk);
    start_nt = 1'b0;
    for (int k = 0; k < 20 && !done_nt; k++) @(negedge clk);
    chk(done_nt && fault_nt, "R8", "fine table faults", {30'b0, done_nt, fault_nt}, 32'd3);
    chk(rd_n_nt == 1, "R8", "no second read", rd_n_nt, 32'd1);
    chk(pa_nt == 32'h0, "R8", "pa zero", pa_nt, 32'h0);
    @(negedge clk);
    rd_n_nt  = 0;
    ttb_nt   = VEC[0].ttb;
    va_nt    = VEC[0].va;
    start_nt = 1'b1;
    @(negedge clk);
    start_nt = 1'b0;
    for (int k = 0; k < 20 && !done_nt; k++) @(negedge clk);
    chk(done_nt && !fault_nt && pa_nt == VEC[0].pa, "R8", "section still maps",
        pa_nt, VEC[0].pa);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule